// File: doc/BRIEF.md
# Half-Bridge Gate Command Interlock

This block turns the two filtered, active-low switch commands of one inverter leg into a pair of registered gate enables, one for the upper switch and one for the lower switch. A three-phase bridge uses three copies. The block never lets both gates be on at once. Whenever one gate turns off, it holds the opposite gate off for a minimum dead band. If the commands already leave a longer gap, the block adds no delay.

The upper gate has two extra protections. The first is an undervoltage lockout for the floating supply. After the supply recovers, the upper gate stays off until its command shows a new high-to-low edge. The second is a hold-off after a qualified negative swing of the switch node. A global drive-off input from the fault controller forces both gates off. The dead-band timers keep running during drive-off, so when drive-off is released the outputs come back under the normal dead-band rules.

All times are counted in clock cycles. `DEAD_CYC` sets the dead band, `QUAL_CYC` sets how long a negative-swing detect must persist, and `HOLD_CYC` sets the upper-gate hold-off. At 100 MHz, typical values are 85, 5 and 450.

Top module: `hbridge_leg_gate`

## Requirements
- R1: Commands are active low and outputs are registered with one cycle of latency. `hi_gate` can be 1 only after a sample with `hi_cmd_n`=0 and `lo_cmd_n`=1, and `lo_gate` only after a sample with `lo_cmd_n`=0 and `hi_cmd_n`=1. Both commands high, or both low, gives both gates 0.
- R2: `hi_gate` and `lo_gate` are never 1 in the same cycle.
- R3: After `hi_gate` falls, `lo_gate` stays 0 for at least `DEAD_CYC` cycles. A pending lower request rises exactly `DEAD_CYC` cycles after the fall, even when the commanded gap was shorter.
- R4: If the opposite gate has already been off for at least `DEAD_CYC` cycles, a request reaches its gate in one cycle, with no added delay.
- R5: The dead band from `lo_gate` falling to `hi_gate` rising is the same `DEAD_CYC` cycles as in R3.
- R6: `hi_supply_low`=1 forces `hi_gate` to 0 from the next cycle and has no effect on `lo_gate`.
- R7: Once `hi_supply_low` has been 1, `hi_gate` stays 0 after the supply recovers. It is released only by a falling edge on `hi_cmd_n` (1 in one sample, 0 in the next) seen while `hi_supply_low`=0. The edge unlocks the upper gate even when the dead band still blocks it at that moment.
- R8: `sw_node_neg` held 1 for `QUAL_CYC` consecutive samples forces `hi_gate` to 0 at that sample's edge. `hi_gate` stays 0 for the next `HOLD_CYC` edges after the last qualifying sample. Shorter pulses are ignored.
- R9: `drive_off`=1 forces both gates to 0 from the next cycle. Dead-band ageing continues during drive-off.
- R10: Reset (`rst_n`=0, asynchronous) clears both gates. It leaves both dead-band timers fully aged, so the first request after reset is granted in one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hi_cmd_n | input | 1 | Upper switch command, active low |
| lo_cmd_n | input | 1 | Lower switch command, active low |
| hi_supply_low | input | 1 | Floating upper supply below its undervoltage threshold |
| sw_node_neg | input | 1 | Raw detect of a negative switch-node swing |
| drive_off | input | 1 | Global disable from the fault controller |
| hi_gate | output | 1 | Upper gate enable, active high |
| lo_gate | output | 1 | Lower gate enable, active high |

## Verification
A dead-band age counter that restarts late, or saturates early, shows up as the opposite gate rising one or more cycles before or after the `DEAD_CYC` mark. The bench times every such rise to the exact cycle. An undervoltage lock that fails to set or to clear appears within a cycle or two of supply recovery: the upper gate returns without the command edge, or never returns after it. A hold-off counter that loads the wrong value, or a qualifier that counts wrongly, moves the upper gate's return by whole cycles. Sustained and interrupted negative-swing pulses expose both faults.

// File: rtl/hbgate_pkg.sv
package hbgate_pkg;
   localparam int NUM_SIDES = 2;
   localparam int SIDE_HI   = 0;
   localparam int SIDE_LO   = 1;
endpackage

// File: rtl/hbgate_dead_age.sv
module hbgate_dead_age #(
   parameter int DEAD_CYC = 85,
   parameter int AGE_W    = $clog2(DEAD_CYC + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             gate_on,
   output logic [AGE_W-1:0] age,
   output logic             ready
);
   localparam logic [AGE_W-1:0] AGE_TOP = AGE_W'(DEAD_CYC);
   localparam logic [AGE_W-1:0] AGE_RDY = AGE_W'(DEAD_CYC - 1);

   initial begin
      assert_dead_param_R3: assert (DEAD_CYC >= 1)
         else $error("DEAD_CYC must be at least 1");
   end

   // Cycles since this side's gate was last on; saturates when fully aged.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             age <= AGE_TOP;
      else if (gate_on)       age <= '0;
      else if (age != AGE_TOP) age <= age + 1'b1;
   end

   // The opposite side may switch on at the next edge.
   assign ready = !gate_on && (age >= AGE_RDY);

   assert_age_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (DEAD_CYC > 1 && $fell(gate_on)) |-> !ready);
endmodule

// File: rtl/hbgate_uv_rearm.sv
module hbgate_uv_rearm (
   input  logic clk,
   input  logic rst_n,
   input  logic supply_low,
   input  logic cmd_n,
   output logic permit
);
   logic cmd_prev;
   logic locked;
   logic fall;

   assign fall   = cmd_prev & ~cmd_n;
   assign permit = ~supply_low & (~locked | fall);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_prev <= 1'b1;
         locked   <= 1'b0;
      end else begin
         cmd_prev <= cmd_n;
         locked   <= supply_low | (locked & ~fall);
      end
   end

   assert_uv_locks_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (supply_low && !fall) |=> !permit || fall);
endmodule

// File: rtl/hbgate_neg_holdoff.sv
module hbgate_neg_holdoff #(
   parameter int QUAL_CYC = 5,
   parameter int HOLD_CYC = 450
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sense,
   output logic block
);
   localparam int HOLD_W = $clog2(HOLD_CYC + 1);
   localparam logic [HOLD_W-1:0] HOLD_TOP = HOLD_W'(HOLD_CYC);

   logic              trig;
   logic [HOLD_W-1:0] hold;

   initial begin
      assert_hold_param_R8: assert (HOLD_CYC >= 1 && QUAL_CYC >= 1)
         else $error("HOLD_CYC and QUAL_CYC must be at least 1");
   end

   generate
      if (QUAL_CYC <= 1) begin : g_direct
         assign trig = sense;
      end else begin : g_count
         localparam int QW = $clog2(QUAL_CYC);
         localparam logic [QW-1:0] RUN_TOP = QW'(QUAL_CYC - 1);
         logic [QW-1:0] run;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              run <= '0;
            else if (!sense)         run <= '0;
            else if (run != RUN_TOP) run <= run + 1'b1;
         end

         assign trig = sense & (run == RUN_TOP);

         assert_short_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (sense && !$past(sense)) |-> !trig);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           hold <= '0;
      else if (trig)        hold <= HOLD_TOP;
      else if (hold != '0)  hold <= hold - 1'b1;
   end

   assign block = trig | (hold != '0);

   assert_hold_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
      trig |=> block);
endmodule

// File: rtl/hbridge_leg_gate.sv
module hbridge_leg_gate
   import hbgate_pkg::*;
#(
   parameter int DEAD_CYC = 85,
   parameter int HOLD_CYC = 450,
   parameter int QUAL_CYC = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hi_cmd_n,
   input  logic lo_cmd_n,
   input  logic hi_supply_low,
   input  logic sw_node_neg,
   input  logic drive_off,
   output logic hi_gate,
   output logic lo_gate
);
   localparam int AGE_W = $clog2(DEAD_CYC + 1);

   logic [NUM_SIDES-1:0] gate_q;
   logic [NUM_SIDES-1:0] gate_d;
   logic [NUM_SIDES-1:0] side_req;
   logic [NUM_SIDES-1:0] side_ready;
   logic [AGE_W-1:0]     off_age [NUM_SIDES];
   logic                 hi_permit;
   logic                 tr_block;

   generate
      for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
         hbgate_dead_age #(.DEAD_CYC(DEAD_CYC), .AGE_W(AGE_W)) u_age (
            .clk     (clk),
            .rst_n   (rst_n),
            .gate_on (gate_q[s]),
            .age     (off_age[s]),
            .ready   (side_ready[s])
         );
      end
   endgenerate

   hbgate_uv_rearm u_uv (
      .clk        (clk),
      .rst_n      (rst_n),
      .supply_low (hi_supply_low),
      .cmd_n      (hi_cmd_n),
      .permit     (hi_permit)
   );

   hbgate_neg_holdoff #(.QUAL_CYC(QUAL_CYC), .HOLD_CYC(HOLD_CYC)) u_neg (
      .clk   (clk),
      .rst_n (rst_n),
      .sense (sw_node_neg),
      .block (tr_block)
   );

   always_comb begin
      side_req[SIDE_HI] = ~hi_cmd_n & lo_cmd_n;
      side_req[SIDE_LO] = hi_cmd_n & ~lo_cmd_n;
      gate_d[SIDE_HI]   = side_req[SIDE_HI] & ~drive_off & hi_permit & ~tr_block
                        & side_ready[SIDE_LO];
      gate_d[SIDE_LO]   = side_req[SIDE_LO] & ~drive_off & side_ready[SIDE_HI];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) gate_q <= '0;
      else        gate_q <= gate_d;
   end

   assign hi_gate = gate_q[SIDE_HI];
   assign lo_gate = gate_q[SIDE_LO];

   assert_no_overlap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(hi_gate && lo_gate));
   assert_hi_decode_R1: assert property (@(posedge clk) disable iff (!rst_n)
      hi_gate |-> $past(!hi_cmd_n && lo_cmd_n));
   assert_lo_decode_R1: assert property (@(posedge clk) disable iff (!rst_n)
      lo_gate |-> $past(!lo_cmd_n && hi_cmd_n));
   assert_dead_hi_to_lo_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lo_gate) |-> (!$past(hi_gate) &&
                          $past(off_age[SIDE_HI]) >= AGE_W'(DEAD_CYC - 1)));
   assert_dead_lo_to_hi_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hi_gate) |-> (!$past(lo_gate) &&
                          $past(off_age[SIDE_LO]) >= AGE_W'(DEAD_CYC - 1)));
   assert_uv_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
      hi_supply_low |=> !hi_gate);
   assert_transient_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
      tr_block |=> !hi_gate);
   assert_disable_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
      drive_off |=> (!hi_gate && !lo_gate));
endmodule

// File: tb/tb_hbridge_leg_gate.sv
`timescale 1ns/100ps
module tb_hbridge_leg_gate;
   localparam int DEAD = 3;
   localparam int HOLD = 5;
   localparam int QUAL = 2;
   localparam int NVEC = 56;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic hi_cmd_n = 1'b1, lo_cmd_n = 1'b1, supply_low = 1'b0, sw_neg = 1'b0, drv_off = 1'b0;
   logic hi_gate, lo_gate;
   int   checks = 0;
   int   errors = 0;
   bit   finished = 1'b0;

   always #2.5 clk = ~clk;

   hbridge_leg_gate #(.DEAD_CYC(DEAD), .HOLD_CYC(HOLD), .QUAL_CYC(QUAL)) dut (
      .clk(clk), .rst_n(rst_n), .hi_cmd_n(hi_cmd_n), .lo_cmd_n(lo_cmd_n),
      .hi_supply_low(supply_low), .sw_node_neg(sw_neg), .drive_off(drv_off),
      .hi_gate(hi_gate), .lo_gate(lo_gate));

   // {req, {hi_cmd_n, lo_cmd_n, supply_low, sw_neg, drv_off}, {exp_hi, exp_lo}}
   localparam logic [10:0] VEC [NVEC] = '{
      {4'd1, 5'b11000, 2'b00},  // 0  R1 both commands high
      {4'd4, 5'b01000, 2'b10},  // 1  R4 aged, immediate
      {4'd1, 5'b01000, 2'b10},  // 2  R1
      {4'd2, 5'b10000, 2'b00},  // 3  R2 swap, upper off
      {4'd3, 5'b10000, 2'b00},  // 4  R3 dead band
      {4'd3, 5'b10000, 2'b00},  // 5  R3
      {4'd3, 5'b10000, 2'b01},  // 6  R3 rises at DEAD
      {4'd1, 5'b10000, 2'b01},  // 7  R1
      {4'd2, 5'b01000, 2'b00},  // 8  R2
      {4'd5, 5'b01000, 2'b00},  // 9  R5
      {4'd5, 5'b01000, 2'b00},  // 10 R5
      {4'd5, 5'b01000, 2'b10},  // 11 R5 rises at DEAD
      {4'd1, 5'b00000, 2'b00},  // 12 R1 both low
      {4'd1, 5'b11000, 2'b00},  // 13 R1
      {4'd1, 5'b11000, 2'b00},  // 14 R1
      {4'd1, 5'b11000, 2'b00},  // 15 R1
      {4'd4, 5'b10000, 2'b01},  // 16 R4 long gap, no delay
      {4'd1, 5'b11000, 2'b00},  // 17 R1
      {4'd3, 5'b01000, 2'b00},  // 18 R3 short gap stretched
      {4'd3, 5'b01000, 2'b00},  // 19 R3
      {4'd3, 5'b01000, 2'b10},  // 20 R3
      {4'd6, 5'b01100, 2'b00},  // 21 R6 supply low
      {4'd6, 5'b01100, 2'b00},  // 22 R6
      {4'd7, 5'b01000, 2'b00},  // 23 R7 recovered, no edge
      {4'd7, 5'b01000, 2'b00},  // 24 R7
      {4'd7, 5'b11000, 2'b00},  // 25 R7
      {4'd7, 5'b01000, 2'b10},  // 26 R7 fresh edge re-arms
      {4'd6, 5'b10100, 2'b00},  // 27 R6
      {4'd6, 5'b10100, 2'b00},  // 28 R6
      {4'd6, 5'b10100, 2'b00},  // 29 R6
      {4'd6, 5'b10100, 2'b01},  // 30 R6 lower unaffected
      {4'd1, 5'b11000, 2'b00},  // 31 R1
      {4'd7, 5'b01000, 2'b00},  // 32 R7 edge during dead band
      {4'd7, 5'b01000, 2'b00},  // 33 R7
      {4'd7, 5'b01000, 2'b10},  // 34 R7 unlocked by earlier edge
      {4'd8, 5'b01010, 2'b10},  // 35 R8 one sample, ignored
      {4'd8, 5'b01000, 2'b10},  // 36 R8
      {4'd8, 5'b01010, 2'b10},  // 37 R8
      {4'd8, 5'b01010, 2'b00},  // 38 R8 qualified
      {4'd8, 5'b01000, 2'b00},  // 39 R8 hold
      {4'd8, 5'b01000, 2'b00},  // 40 R8
      {4'd8, 5'b01000, 2'b00},  // 41 R8
      {4'd8, 5'b01000, 2'b00},  // 42 R8
      {4'd8, 5'b01000, 2'b00},  // 43 R8
      {4'd8, 5'b01000, 2'b10},  // 44 R8 hold over
      {4'd9, 5'b01001, 2'b00},  // 45 R9 drive off
      {4'd9, 5'b10001, 2'b00},  // 46 R9
      {4'd9, 5'b10000, 2'b00},  // 47 R9 dead band ran through
      {4'd9, 5'b10000, 2'b01},  // 48 R9
      {4'd9, 5'b10001, 2'b00},  // 49 R9
      {4'd9, 5'b11001, 2'b00},  // 50 R9
      {4'd9, 5'b11001, 2'b00},  // 51 R9
      {4'd9, 5'b11001, 2'b00},  // 52 R9 aged under drive off
      {4'd9, 5'b01000, 2'b10},  // 53 R9 immediate on release
      {4'd9, 5'b01000, 2'b10},  // 54 R9
      {4'd1, 5'b11000, 2'b00}   // 55 R1
   };

   task automatic check(input string req, input logic act, input logic exp, input string what);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual %b expected %b at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic apply(input logic [4:0] v);
      @(negedge clk);
      {hi_cmd_n, lo_cmd_n, supply_low, sw_neg, drv_off} = v;
      @(posedge clk);
      #1;
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      check("R10", hi_gate, 1'b0, "hi_gate in reset");
      check("R10", lo_gate, 1'b0, "lo_gate in reset");
      @(negedge clk) rst_n = 1'b1;

      for (int i = 0; i < NVEC; i++) begin
         apply(VEC[i][6:2]);
         check($sformatf("R%0d", VEC[i][10:7]), hi_gate, VEC[i][1], $sformatf("hi_gate row %0d", i));
         check($sformatf("R%0d", VEC[i][10:7]), lo_gate, VEC[i][0], $sformatf("lo_gate row %0d", i));
         check("R2", hi_gate & lo_gate, 1'b0, $sformatf("overlap row %0d", i));
      end

      // R8: sustained swing keeps re-arming the hold-off
      apply(5'b01000);
      check("R8", hi_gate, 1'b1, "hi_gate before sustained swing");
      for (int k = 1; k <= 12; k++) begin
         apply(5'b01010);
         check("R8", hi_gate, (k == 1), $sformatf("hi_gate sustained swing step %0d", k));
      end
      for (int j = 1; j <= HOLD + 1; j++) begin
         apply(5'b01000);
         check("R8", hi_gate, (j == HOLD + 1), $sformatf("hi_gate after swing step %0d", j));
      end

      // R10: reset mid-run leaves timers aged; lower request granted at once
      apply(5'b01000);
      check("R10", hi_gate, 1'b1, "hi_gate before reset");
      @(negedge clk);
      rst_n = 1'b0;
      {hi_cmd_n, lo_cmd_n, supply_low, sw_neg, drv_off} = 5'b10000;
      @(posedge clk);
      #1;
      check("R10", hi_gate, 1'b0, "hi_gate during reset");
      check("R10", lo_gate, 1'b0, "lo_gate during reset");
      @(negedge clk) rst_n = 1'b1;
      @(posedge clk);
      #1;
      check("R10", lo_gate, 1'b1, "lo_gate first cycle after reset");
      check("R10", hi_gate, 1'b0, "hi_gate first cycle after reset");

      finish_run();
   end

   initial begin
      repeat (5000) @(posedge clk);
      errors++;
      $display("FAIL watchdog all requirements actual running expected finished");
      finish_run();
   end
endmodule